// File: doc/BRIEF.md
# ARINC Word Acceptance Filter and Receive Queue

This block sits behind an ARINC 429 bit receiver. Each time the receiver finishes a 32-bit word, it presents the word together with a one-cycle completion strobe. The block can rewrite bit 32 as a parity-error indicator. It then decides whether to keep the word, using a 256-entry label enable map and a compare on ARINC bits 9 and 10. Words that are kept go into a 32-deep first-in first-out queue.

A host-side agent drains the queue with a one-cycle read request and gets the word on a registered read port. The block reports whether the queue is empty, at least half full or full. It also drives one interrupt line, and a select input picks whether that line shows the empty flag or the full flag. A synchronous clear input empties the queue and its flags. The control inputs are not state of this block, so the clear does not touch them.

ARINC bit n is carried on `word_in[n-1]`: the label is `word_in[7:0]`, bit 9 is `word_in[8]`, bit 10 is `word_in[9]`, and bit 32 is `word_in[31]`.

Top module: `arw_filter_fifo`

## Requirements
- R1: With `par_chk_en` = 0, bit 32 of a stored word equals `word_in[31]` as received.
- R2: With `par_chk_en` = 1, bit 32 of a stored word is 0 when the 32 received bits contain an odd number of ones, and 1 when they contain an even number. Bits 31..1 are stored unchanged.
- R3: With `lbl_flt_en` = 1, a strobed word is stored only if `lbl_map[word_in[7:0]]` is 1. With `lbl_flt_en` = 0, the map is not consulted.
- R4: With `dec_cmp_en` = 1, a strobed word is stored only if `word_in[9]` equals `dec_b10` and `word_in[8]` equals `dec_b9`.
- R5: When both the label filter and the decode compare are enabled, a word is stored only if it passes both.
- R6: The queue holds up to 32 words and returns them in arrival order. Each read request returns one word on `rd_word` at the clock edge that samples the request.
- R7: `st_half` is 1 exactly when 16 or more words are held.
- R8: `st_full` is 1 when 32 words are held. If a word is accepted while the queue is full and no read is requested, it replaces the most recently stored word, and the occupancy stays at 32.
- R9: `st_empty` is 1 when no word is held, and it goes to 0 at the edge that stores a word.
- R10: `irq` equals `st_empty` when `irq_sel` = 0 and equals `st_full` when `irq_sel` = 1.
- R11: A high `mreset` at a clock edge discards all held words, sets `st_empty` and clears `st_half`, `st_full` and `rd_word`. Filtering of later words still follows the control inputs.
- R12: A strobed word that is rejected changes neither the occupancy nor any status output.
- R13: A read request on an empty queue sets `rd_word` to all zeros and leaves the queue empty.
- R14: If a word is accepted and a read is requested in the same cycle on a non-empty queue, both take place and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreset | input | 1 | Synchronous clear of the queue and its flags |
| word_in | input | 32 | Completed ARINC word, ARINC bit n on index n-1 |
| eos | input | 1 | One-cycle strobe: `word_in` is complete |
| par_chk_en | input | 1 | Rewrite bit 32 as the parity-error indicator |
| lbl_flt_en | input | 1 | Enable the label map filter |
| dec_cmp_en | input | 1 | Enable the bit 10/9 compare |
| dec_b10 | input | 1 | Required value of ARINC bit 10 |
| dec_b9 | input | 1 | Required value of ARINC bit 9 |
| irq_sel | input | 1 | 0: `irq` shows empty, 1: `irq` shows full |
| lbl_map | input | 256 | Label enable map, indexed by label |
| pop | input | 1 | One-cycle read request |
| rd_word | output | 32 | Word returned by the last read request |
| st_empty | output | 1 | Queue holds no word |
| st_half | output | 1 | Queue holds 16 or more words |
| st_full | output | 1 | Queue holds 32 words |
| irq | output | 1 | Selected flag |

## Verification
The accept decision is combinational, so a word strobed in one cycle is already counted in the status flags just after the next rising edge. A read request presents its word on `rd_word` after that same edge, and `mreset` takes effect at that edge too. The bench changes inputs on falling edges. At each rising edge a monitor advances a reference queue from the inputs in force, then compares the flags, `irq` and any returned word 2 ns after the edge, so every result is checked in the cycle it is due.

// File: rtl/arw_pkg.sv
package arw_pkg;

  // filter controls gathered for the accept stage
  typedef struct packed {
    logic lbl_en;
    logic dec_en;
    logic b10;
    logic b9;
  } arw_flt_ctl_t;

endpackage

// File: rtl/arw_parity.sv
module arw_parity #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic odd_ones;

  always_comb begin
    odd_ones = ^din;
    dout     = din;
    if (en) begin
      dout[W-1] = ~odd_ones;
    end
  end

endmodule

// File: rtl/arw_accept.sv
module arw_accept
  import arw_pkg::*;
#(
  parameter int W     = 32,
  parameter int LBL_W = 8
) (
  input  logic               [W-1:0]          word,
  input  logic               [(1<<LBL_W)-1:0] map,
  input  arw_flt_ctl_t                        ctl,
  output logic                                pass
);

  localparam int B9_IDX  = LBL_W;
  localparam int B10_IDX = LBL_W + 1;

  logic lbl_ok;
  logic dec_ok;

  always_comb begin
    lbl_ok = !ctl.lbl_en || map[word[LBL_W-1:0]];
    dec_ok = !ctl.dec_en ||
             ((word[B10_IDX] == ctl.b10) && (word[B9_IDX] == ctl.b9));
    pass   = lbl_ok && dec_ok;
  end

endmodule

// File: rtl/arw_fifo.sv
module arw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         empty,
  output logic                         half,
  output logic                         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d, wa;
  logic [CW-1:0] occ_q, occ_d;
  logic [W-1:0]  dout_q, dout_d;
  logic          do_pop, at_cap, ovw, adv, we;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_prev(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - AW'(1);
  endfunction

  always_comb begin
    do_pop = pop && (occ_q != '0);
    at_cap = (occ_q == CW'(DEPTH));
    ovw    = push && at_cap && !do_pop;
    adv    = push && !ovw;
    we     = push && !clr;
    wa     = ovw ? ptr_prev(wr_q) : wr_q;

    wr_d   = wr_q;
    rd_d   = rd_q;
    occ_d  = occ_q;
    dout_d = dout_q;
    if (clr) begin
      wr_d   = '0;
      rd_d   = '0;
      occ_d  = '0;
      dout_d = '0;
    end else begin
      if (adv)    wr_d = ptr_next(wr_q);
      if (do_pop) rd_d = ptr_next(rd_q);
      if (pop)    dout_d = do_pop ? mem[rd_q] : '0;
      if (adv && !do_pop)      occ_d = occ_q + CW'(1);
      else if (!adv && do_pop) occ_d = occ_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      occ_q  <= '0;
      dout_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      occ_q  <= occ_d;
      dout_q <= dout_d;
    end
  end

  // storage array: written only on an enabled cycle, no reset needed
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa] <= din;
    end
  end

  assign dout  = dout_q;
  assign occ   = occ_q;
  assign empty = (occ_q == '0);
  assign half  = (occ_q >= CW'(DEPTH / 2));
  assign full  = at_cap;

endmodule

// File: rtl/arw_filter_fifo.sv
module arw_filter_fifo
  import arw_pkg::*;
#(
  parameter int W     = 32,
  parameter int LBL_W = 8,
  parameter int DEPTH = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mreset,
  input  logic [W-1:0]            word_in,
  input  logic                    eos,
  input  logic                    par_chk_en,
  input  logic                    lbl_flt_en,
  input  logic                    dec_cmp_en,
  input  logic                    dec_b10,
  input  logic                    dec_b9,
  input  logic                    irq_sel,
  input  logic [(1<<LBL_W)-1:0]   lbl_map,
  input  logic                    pop,
  output logic [W-1:0]            rd_word,
  output logic                    st_empty,
  output logic                    st_half,
  output logic                    st_full,
  output logic                    irq
);

  localparam int CW = $clog2(DEPTH + 1);

  arw_flt_ctl_t  ctl;
  logic [W-1:0]  fixed_word;
  logic          pass;
  logic          push;
  logic [CW-1:0] occ;

  always_comb begin
    ctl.lbl_en = lbl_flt_en;
    ctl.dec_en = dec_cmp_en;
    ctl.b10    = dec_b10;
    ctl.b9     = dec_b9;
  end

  arw_parity #(.W(W)) u_par (
    .en   (par_chk_en),
    .din  (word_in),
    .dout (fixed_word)
  );

  arw_accept #(.W(W), .LBL_W(LBL_W)) u_acc (
    .word (word_in),
    .map  (lbl_map),
    .ctl  (ctl),
    .pass (pass)
  );

  assign push = eos && pass;

  arw_fifo #(.W(W), .DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mreset),
    .push  (push),
    .pop   (pop),
    .din   (fixed_word),
    .dout  (rd_word),
    .occ   (occ),
    .empty (st_empty),
    .half  (st_half),
    .full  (st_full)
  );

  assign irq = irq_sel ? st_full : st_empty;

endmodule

// File: rtl/arw_filter_fifo_chk.sv
module arw_filter_fifo_chk #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mreset,
  input logic          eos,
  input logic          pass,
  input logic          pop,
  input logic          irq_sel,
  input logic          st_empty,
  input logic          st_half,
  input logic          st_full,
  input logic          irq,
  input logic [W-1:0]  rd_word,
  input logic [CW-1:0] occ
);

  p_full_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> st_half);

  p_empty_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> (!st_half && !st_full));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_empty && eos && pass && !mreset) |=> !st_empty);

  p_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && eos && pass && !pop && !mreset) |=> st_full);

  p_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!(eos && pass) && !pop && !mreset) |=> $stable(occ));

  p_pushpop_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && pass && pop && !st_empty && !mreset) |=> $stable(occ));

  p_pop_empty_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_empty && pop && !eos && !mreset) |=> (st_empty && rd_word == '0));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (st_empty && !st_half && rd_word == '0));

  p_irq_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_sel && st_empty) |-> irq);

  p_irq_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sel && !st_full) |-> !irq);

endmodule

bind arw_filter_fifo arw_filter_fifo_chk #(.W(W), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mreset   (mreset),
  .eos      (eos),
  .pass     (pass),
  .pop      (pop),
  .irq_sel  (irq_sel),
  .st_empty (st_empty),
  .st_half  (st_half),
  .st_full  (st_full),
  .irq      (irq),
  .rd_word  (rd_word),
  .occ      (occ)
);

// File: tb/tb_arw_filter_fifo.sv
`timescale 1ns/1ps
module tb_arw_filter_fifo;

  logic         clk;
  logic         rst_n;
  logic         mreset;
  logic [31:0]  word_in;
  logic         eos;
  logic         par_chk_en, lbl_flt_en, dec_cmp_en, dec_b10, dec_b9, irq_sel;
  logic [255:0] lbl_map;
  logic         pop;
  logic [31:0]  rd_word;
  logic         st_empty, st_half, st_full, irq;

  int           n_vec;
  int           n_bad;
  int           cyc;
  bit           done;
  string        cur_req;
  logic [31:0]  sb[$];

  arw_filter_fifo dut (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .word_in(word_in), .eos(eos),
    .par_chk_en(par_chk_en), .lbl_flt_en(lbl_flt_en), .dec_cmp_en(dec_cmp_en),
    .dec_b10(dec_b10), .dec_b9(dec_b9), .irq_sel(irq_sel), .lbl_map(lbl_map),
    .pop(pop), .rd_word(rd_word), .st_empty(st_empty), .st_half(st_half),
    .st_full(st_full), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // reference acceptance, from the requirement text
  function automatic bit ref_accept(input logic [31:0] w);
    bit ok;
    ok = 1'b1;
    if (lbl_flt_en && (lbl_map[w[7:0]] == 1'b0)) ok = 1'b0;
    if (dec_cmp_en && ((w[9] != dec_b10) || (w[8] != dec_b9))) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [31:0] ref_store(input logic [31:0] w);
    logic [31:0] r;
    r = w;
    if (par_chk_en) r[31] = ($countones(w) % 2 == 0) ? 1'b1 : 1'b0;
    return r;
  endfunction

  // monitor: advances the scoreboard at each edge and compares afterwards
  always begin
    logic [31:0] exp_rd;
    bit          chk_rd;
    int          sz;
    @(posedge clk);
    chk_rd = 1'b0;
    exp_rd = '0;
    if (rst_n) begin
      if (mreset) begin
        sb.delete();
        chk_rd = 1'b1;
      end else begin
        if (pop) begin
          chk_rd = 1'b1;
          if (sb.size() > 0) begin
            exp_rd = sb[0];
            sb.delete(0);
          end
        end
        if (eos && ref_accept(word_in)) begin
          if (sb.size() == 32) sb[31] = ref_store(word_in);
          else sb.push_back(ref_store(word_in));
        end
      end
      #2;
      sz = sb.size();
      if (chk_rd) check("rd_word R6", rd_word, exp_rd);
      check("st_empty R9", {31'b0, st_empty}, {31'b0, sz == 0});
      check("st_half R7", {31'b0, st_half}, {31'b0, sz >= 16});
      check("st_full R8", {31'b0, st_full}, {31'b0, sz == 32});
      check("irq R10", {31'b0, irq}, {31'b0, irq_sel ? (sz == 32) : (sz == 0)});
    end
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    word_in = w;
    eos     = 1'b1;
    @(negedge clk);
    eos     = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic send_take(input logic [31:0] w);
    @(negedge clk);
    word_in = w;
    eos     = 1'b1;
    pop     = 1'b1;
    @(negedge clk);
    eos     = 1'b0;
    pop     = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() > 0) take();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        summary();
      end
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0; cur_req = "R9";
    rst_n = 1'b0; mreset = 1'b0; word_in = '0; eos = 1'b0; pop = 1'b0;
    par_chk_en = 1'b0; lbl_flt_en = 1'b0; dec_cmp_en = 1'b0;
    dec_b10 = 1'b0; dec_b9 = 1'b0; irq_sel = 1'b0; lbl_map = '0;
    repeat (3) @(negedge clk);
    // reset state (R9)
    check("reset empty", {31'b0, st_empty}, 32'd1);
    check("reset full", {31'b0, st_full}, 32'd0);
    check("reset rd_word", rd_word, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: bit 32 passes untouched
    cur_req = "R1";
    send(32'h8000_0001);
    send(32'h8000_0003);
    send(32'h0000_0007);
    drain();

    // R2: parity rewrite, odd and even words
    cur_req = "R2";
    par_chk_en = 1'b1;
    send(32'h8000_0001);   // even ones -> 1
    send(32'h0000_0001);   // odd ones  -> 0
    send(32'h8000_0000);   // odd ones  -> 0
    send(32'h1234_5678);
    drain();
    par_chk_en = 1'b0;

    // R3: label map filter
    cur_req = "R3";
    lbl_map = '0;
    lbl_map[8'h2A] = 1'b1;
    lbl_map[8'hFF] = 1'b1;
    lbl_flt_en = 1'b1;
    send(32'h0000_002A);
    send(32'h0000_002B);
    send(32'h0000_00FF);
    send(32'h0000_0000);
    drain();
    lbl_flt_en = 1'b0;
    send(32'h0000_0011);   // map ignored when disabled
    drain();

    // R4: bit 10/9 compare
    cur_req = "R4";
    dec_cmp_en = 1'b1; dec_b10 = 1'b1; dec_b9 = 1'b0;
    send(32'h0000_0200);
    send(32'h0000_0100);
    send(32'h0000_0300);
    send(32'h0000_0000);
    drain();

    // R5: both checks at once
    cur_req = "R5";
    lbl_flt_en = 1'b1;
    send(32'h0000_022A);   // both pass
    send(32'h0000_012A);   // label ok, decode bad
    send(32'h0000_022B);   // decode ok, label bad
    drain();

    // R12: rejected words while holding data
    cur_req = "R12";
    send(32'h0000_02FF);
    send(32'h0000_0001);
    send(32'h0000_01FF);
    drain();
    lbl_flt_en = 1'b0; dec_cmp_en = 1'b0;

    // R6/R7/R8: fill past capacity, overwrite last slot
    cur_req = "R8";
    irq_sel = 1'b1;
    for (int i = 0; i < 34; i++) send(32'hA500_0000 + i);
    // R10 with irq showing full
    cur_req = "R14";
    send_take(32'h5A5A_5A5A);
    send_take(32'h5A5A_0001);
    cur_req = "R6";
    irq_sel = 1'b0;
    drain();

    // R13: read on empty
    cur_req = "R13";
    take();
    take();

    // R14 on a small queue
    cur_req = "R14";
    send(32'h0000_1111);
    send_take(32'h0000_2222);
    drain();

    // R11: synchronous clear
    cur_req = "R11";
    for (int i = 0; i < 20; i++) send(32'hC000_0000 + i);
    @(negedge clk);
    mreset = 1'b1;
    @(negedge clk);
    mreset = 1'b0;
    take();
    lbl_flt_en = 1'b1;
    send(32'h0000_002A);
    send(32'h0000_0033);
    drain();

    repeat (2) @(negedge clk);
    summary();
  end

endmodule